// File: doc/BRIEF.md
# Edge-Kicked Watchdog Reset Generator

This block supervises a host by watching one kick line. Each change of level on that line, rising or falling, shows that the host is alive and starts a fresh timeout interval. If the line stays quiet for a whole interval, the block drives its active-low reset output low for a fixed pulse. It then releases reset and starts counting a new interval from zero. The timeout interval and the pulse width are parameters counted in clock cycles.

Three digital flags change this behaviour. The first reports that the kick line is floating. While it is set, the block kicks itself at half the interval, so a timeout never fires. The second is an undervoltage flag. It holds reset low, and a full pulse runs after it clears before reset releases. The third selects how the block treats kicks that arrive while reset is low. In compatible mode those kicks are ignored. In legacy mode any such kick locks reset low until the next power-on reset.

The kick line is an asynchronous input. It passes through a two-flop synchronizer, and an edge is found by comparing the synchronized value with its value one cycle earlier. The power-on reset input is synchronous and active high.

Top module: `wdg_supervisor`

## Requirements
- R1: A rising or a falling change on `kick_i` clears the timeout count. This takes effect at the third rising clock edge after the input changes. Kick changes that are 32 or fewer cycles apart (TIMEOUT_CYC = 32) never let reset assert.
- R2: With no kick, `rst_n_o` stays high for exactly TIMEOUT_CYC cycles after it rises. It then goes low for exactly PULSE_CYC cycles.
- R3: Each reset event restarts the timeout count from zero, so a full TIMEOUT_CYC interval follows every release of reset.
- R4: While `float_i` is high and `uv_i` is low, the block kicks itself whenever its timeout count reaches TIMEOUT_CYC/2 - 1 or more, and reset never asserts because of a timeout.
- R5: With `legacy_i` = 1, a kick edge seen while reset is low locks `rst_n_o` low.
- R6: The locked state ignores further kicks and changes of `uv_i`. Only `por` clears it, and a normal PULSE_CYC pulse follows.
- R7: With `legacy_i` = 0, kick edges while reset is low have no effect, and reset releases exactly PULSE_CYC cycles after it asserted.
- R8: `uv_i` high drives `rst_n_o` low at the next clock edge and holds it low. Reset rises at the PULSE_CYC-th clock edge after the first edge that sees `uv_i` low.
- R9: While `por` is high, `rst_n_o` is low and all counters are cleared. `rst_n_o` rises at the PULSE_CYC-th clock edge after `por` falls. The kick line is expected to be low during `por`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| kick_i | input | 1 | Asynchronous kick line; either edge is a kick |
| float_i | input | 1 | Kick line is floating; enables internal kicks |
| uv_i | input | 1 | Undervoltage flag; holds reset asserted |
| legacy_i | input | 1 | 1: kicks during reset lock reset; 0: they are ignored |
| rst_n_o | output | 1 | Registered active-low reset output |

## Verification
A kick reaches the timeout counter at the third clock edge after the input changes. The changes to `uv_i` and `por` act at the next edge, and reset falls at the TIMEOUT_CYC-th edge after it rises. The bench drives inputs on falling edges and samples on falling edges, and it counts falling edges from a known rising edge of `rst_n_o`. It checks the exact cycle on both sides of each expected transition, for example high at cycle 39 and low at cycle 40 after a kick at cycle 5. The table rows count the low cycles across a fixed 200-cycle window. That count only comes out right if every timeout, pulse and ignored kick lands on its computed cycle.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_RST  = 2'd1,
    ST_LOCK = 2'd2
  } wdg_state_e;

endpackage

// File: rtl/wdg_edge_sync.sv
module wdg_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic por,
  input  logic async_i,
  output logic edge_o
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (por) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  // any change of level, rising or falling
  assign edge_o = sync_q[STAGES-1] ^ prev_q;

endmodule

// File: rtl/wdg_timer.sv
module wdg_timer #(
  parameter int TIMEOUT_CYC = 32
) (
  input  logic clk,
  input  logic por,
  input  logic run_i,
  input  logic kick_edge_i,
  input  logic float_i,
  output logic expire_o
);

  localparam int TW   = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
  localparam int HALF = (TIMEOUT_CYC / 2 > 0) ? TIMEOUT_CYC / 2 : 1;
  localparam logic [TW-1:0] CNT_MAX  = TW'(TIMEOUT_CYC - 1);
  localparam logic [TW-1:0] SELF_AT  = TW'(HALF - 1);

  logic [TW-1:0] cnt_q;
  logic          self_kick;
  logic          kick_any;

  // internal kick at half interval; >= covers a float flag raised late
  assign self_kick = float_i && (cnt_q >= SELF_AT);
  assign kick_any  = kick_edge_i || self_kick;
  assign expire_o  = run_i && (cnt_q == CNT_MAX) && !kick_any;

  always_ff @(posedge clk) begin
    if (por || !run_i) begin
      cnt_q <= '0;
    end else if (kick_any) begin
      cnt_q <= '0;
    end else if (cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/wdg_pulse_fsm.sv
module wdg_pulse_fsm
  import wdg_pkg::*;
#(
  parameter int PULSE_CYC = 8
) (
  input  logic       clk,
  input  logic       por,
  input  logic       expire_i,
  input  logic       kick_edge_i,
  input  logic       uv_i,
  input  logic       legacy_i,
  output wdg_state_e state_o,
  output logic       rst_n_o
);

  localparam int PW = (PULSE_CYC > 2) ? $clog2(PULSE_CYC) : 1;
  localparam logic [PW-1:0] PCNT_MAX = PW'(PULSE_CYC - 1);

  wdg_state_e    state_q, state_nx;
  logic [PW-1:0] pcnt_q;
  logic          rst_n_q;

  always_comb begin
    state_nx = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (uv_i || expire_i) state_nx = ST_RST;
      end
      ST_RST: begin
        if (legacy_i && kick_edge_i)        state_nx = ST_LOCK;
        else if (!uv_i && pcnt_q == PCNT_MAX) state_nx = ST_RUN;
      end
      ST_LOCK: state_nx = ST_LOCK;
      default: state_nx = ST_RST;
    endcase
  end

  always_ff @(posedge clk) begin
    if (por) begin
      state_q <= ST_RST;
      pcnt_q  <= '0;
      rst_n_q <= 1'b0;
    end else begin
      state_q <= state_nx;
      rst_n_q <= (state_nx == ST_RUN);
      if (state_q != ST_RST || uv_i) begin
        pcnt_q <= '0;
      end else if (pcnt_q != PCNT_MAX) begin
        pcnt_q <= pcnt_q + 1'b1;
      end
    end
  end

  assign state_o = state_q;
  assign rst_n_o = rst_n_q;

endmodule

// File: rtl/wdg_supervisor.sv
module wdg_supervisor
  import wdg_pkg::*;
#(
  parameter int TIMEOUT_CYC = 64,
  parameter int PULSE_CYC   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic por,
  input  logic kick_i,
  input  logic float_i,
  input  logic uv_i,
  input  logic legacy_i,
  output logic rst_n_o
);

  logic       kick_edge;
  logic       expire;
  logic       lock_q;
  wdg_state_e state;

  wdg_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .por     (por),
    .async_i (kick_i),
    .edge_o  (kick_edge)
  );

  wdg_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk         (clk),
    .por         (por),
    .run_i       (state == ST_RUN),
    .kick_edge_i (kick_edge),
    .float_i     (float_i),
    .expire_o    (expire)
  );

  wdg_pulse_fsm #(.PULSE_CYC(PULSE_CYC)) u_fsm (
    .clk         (clk),
    .por         (por),
    .expire_i    (expire),
    .kick_edge_i (kick_edge),
    .uv_i        (uv_i),
    .legacy_i    (legacy_i),
    .state_o     (state),
    .rst_n_o     (rst_n_o)
  );

  assign lock_q = (state == ST_LOCK);

endmodule

// File: rtl/wdg_supervisor_chk.sv
module wdg_supervisor_chk #(
  parameter int PULSE_CYC = 16
) (
  input logic clk,
  input logic por,
  input logic uv_i,
  input logic float_i,
  input logic rst_n_o,
  input logic locked
);

  logic [15:0] low_run;

  always_ff @(posedge clk) begin
    if (por)            low_run <= '0;
    else if (rst_n_o)   low_run <= '0;
    else if (low_run != 16'hFFFF) low_run <= low_run + 1'b1;
  end

  // R9: power-on reset forces the output low
  assert_por_low_R9: assert property (@(posedge clk) por |=> !rst_n_o);

  // R8: undervoltage forces the output low at the next edge
  assert_uv_low_R8: assert property (@(posedge clk) disable iff (por)
    uv_i |=> !rst_n_o);

  // R6: once locked, stays locked with reset low until power-on reset
  assert_lock_hold_R6: assert property (@(posedge clk) disable iff (por)
    locked |=> (locked && !rst_n_o));

  // R4: floating input keeps a released reset released
  assert_float_no_to_R4: assert property (@(posedge clk) disable iff (por)
    (rst_n_o && float_i && !uv_i) |=> rst_n_o);

  // R2: every release follows at least a full pulse of low cycles
  assert_pulse_min_R2: assert property (@(posedge clk) disable iff (por)
    $rose(rst_n_o) |-> (low_run >= 16'(PULSE_CYC)));

endmodule

bind wdg_supervisor wdg_supervisor_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
  .clk     (clk),
  .por     (por),
  .uv_i    (uv_i),
  .float_i (float_i),
  .rst_n_o (rst_n_o),
  .locked  (lock_q)
);

// File: tb/wdg_supervisor_tb.sv
module wdg_supervisor_tb_top;

  localparam int T   = 32;
  localparam int P   = 8;
  localparam int WIN = 200;

  logic clk = 1'b0;
  logic por = 1'b1;
  logic kick_i = 1'b0;
  logic float_i = 1'b0;
  logic uv_i = 1'b0;
  logic legacy_i = 1'b0;
  logic rst_n_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  wdg_supervisor #(.TIMEOUT_CYC(T), .PULSE_CYC(P)) dut_i (
    .clk      (clk),
    .por      (por),
    .kick_i   (kick_i),
    .float_i  (float_i),
    .uv_i     (uv_i),
    .legacy_i (legacy_i),
    .rst_n_o  (rst_n_o)
  );

  typedef struct packed {
    logic flt;
    int   gap;      // 0 = no kicks
    int   exp_low;  // low cycles in WIN-cycle window
  } row_t;

  // row 0: R1 steady kicks; row 1: R1 boundary gap = T
  // row 2: R2/R3 no kicks (40 = 5 pulses of 8)
  // row 3,4: R4 floating input
  // row 5: R7 gap 40, kicks in reset ignored (8+8+8+8+5)
  localparam row_t ROWS [6] = '{
    '{1'b0, 10, 0},
    '{1'b0, 32, 0},
    '{1'b0, 0,  40},
    '{1'b1, 0,  0},
    '{1'b1, 40, 0},
    '{1'b0, 40, 37}
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic chk_int(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // power-on reset, then check release after exactly P edges (R9)
  task automatic do_por();
    int k;
    @(negedge clk);
    kick_i = 1'b0;
    por = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 low during por", rst_n_o, 1'b0);
    por = 1'b0;
    k = 0;
    while (k < 100) begin
      @(negedge clk);
      k++;
      if (rst_n_o) break;
    end
    chk_int("R9 release cycle after por", k, P);
  endtask

  task automatic wait_high();
    for (int k = 0; k < 200; k++) begin
      if (rst_n_o) break;
      @(negedge clk);
    end
  endtask

  // advance from sample index cur to target index, no stimulus
  task automatic adv(inout int cur, input int target);
    while (cur < target) begin
      @(negedge clk);
      cur++;
    end
  endtask

  initial begin
    int i;
    int lows;
    // table walk
    for (int r = 0; r < 6; r++) begin
      float_i  = ROWS[r].flt;
      legacy_i = 1'b0;
      do_por();
      lows = 0;
      for (int s = 0; s < WIN; s++) begin
        if (!rst_n_o) lows++;
        if (ROWS[r].gap > 0 && (s % ROWS[r].gap) == 0) kick_i = ~kick_i;
        @(negedge clk);
      end
      chk_int($sformatf("table row %0d low cycles", r), lows, ROWS[r].exp_low);
    end
    float_i = 1'b0;

    // R1 rising kick at 5: reset falls at 5+3+T = 40
    do_por();
    i = 0;
    adv(i, 5);
    kick_i = 1'b1;
    adv(i, 39);
    chk("R1 rising kick, high at 39", rst_n_o, 1'b1);
    adv(i, 40);
    chk("R1 rising kick, low at 40", rst_n_o, 1'b0);
    // R3: release at 48, then a full T interval again
    adv(i, 48);
    chk("R3 release after pulse", rst_n_o, 1'b1);
    i = 0;
    adv(i, 5);
    kick_i = 1'b0;  // R1 falling kick
    adv(i, 39);
    chk("R1 falling kick, high at 39", rst_n_o, 1'b1);
    adv(i, 40);
    chk("R1 falling kick, low at 40", rst_n_o, 1'b0);

    // R2 exact timeout with no kick
    do_por();
    i = 0;
    adv(i, 31);
    chk("R2 high at T-1", rst_n_o, 1'b1);
    adv(i, 32);
    chk("R2 low at T", rst_n_o, 1'b0);
    adv(i, 39);
    chk("R2 low at T+P-1", rst_n_o, 1'b0);
    adv(i, 40);
    chk("R2 high at T+P", rst_n_o, 1'b1);

    // R8 undervoltage
    do_por();
    i = 0;
    adv(i, 4);
    uv_i = 1'b1;
    adv(i, 5);
    chk("R8 low one edge after uv", rst_n_o, 1'b0);
    adv(i, 20);
    chk("R8 held low during uv", rst_n_o, 1'b0);
    uv_i = 1'b0;
    adv(i, 27);
    chk("R8 still low P-1 after clear", rst_n_o, 1'b0);
    adv(i, 28);
    chk("R8 high P after clear", rst_n_o, 1'b1);

    // R7 compatible mode: kick during reset ignored
    legacy_i = 1'b0;
    do_por();
    i = 0;
    adv(i, 33);
    kick_i = 1'b1;
    adv(i, 39);
    chk("R7 low before normal release", rst_n_o, 1'b0);
    adv(i, 40);
    chk("R7 normal release despite kick", rst_n_o, 1'b1);

    // R5 legacy mode without kick in reset releases normally
    legacy_i = 1'b1;
    do_por();
    i = 0;
    adv(i, 40);
    chk("R5 legacy, no kick in reset, releases", rst_n_o, 1'b1);

    // R5/R6 legacy mode: kick in reset locks
    do_por();
    i = 0;
    adv(i, 33);
    kick_i = 1'b1;
    adv(i, 40);
    chk("R5 locked at normal release time", rst_n_o, 1'b0);
    uv_i = 1'b1;
    adv(i, 60);
    uv_i = 1'b0;
    kick_i = 1'b0;
    adv(i, 300);
    chk("R6 lock survives uv clear and kicks", rst_n_o, 1'b0);
    do_por();  // R6: por clears lock, release after P (checked inside)
    chk("R6 released after por", rst_n_o, 1'b1);
    legacy_i = 1'b0;
    wait_high();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule